// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Two Rounding Modes

The block adds two binary32 floating-point operands in a two-stage pipeline. An operand pair that arrives with its valid strobe leaves as a packed 32-bit sum two clock edges later, with a matching output strobe. A new pair may enter on every cycle. The first stage unpacks and orders the operands and aligns the smaller one, keeping guard, round and sticky bits. It then adds or subtracts the magnitudes. The second stage normalizes the result, rounds it, and handles exponent overflow and underflow.

A single control bit picks the rounding behaviour for each operation. One setting chops every bit below the kept mantissa. The other rounds to the nearest value and breaks exact ties toward the even mantissa. Repeated accumulation therefore drifts apart between the two settings. The block keeps its arithmetic simple on purpose. Non-numeric operands behave as infinities, no NaN is ever produced, and values below the smallest normal magnitude are flushed to zero.

Top module: `sp_fadd`

## Requirements
- R1: `out_valid` is high on the second rising edge after a rising edge that samples `in_valid` high, and `sum` holds that pair's result in the same cycle. Pairs may enter on consecutive cycles. Otherwise `out_valid` is low.
- R2: `rnd_near` = 1 selects round-to-nearest-even. `rnd_near` = 0 selects truncation, which discards every bit below the 23-bit fraction whatever its value (e.g. 0x3F800000 + 0x33C00000 gives 0x3F800000).
- R3: In nearest mode, a remainder under half an ulp is dropped and one over half an ulp increments the fraction. An exact half goes to the even fraction: 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R4: An operand with exponent field 255 is an infinity of its own sign, whatever its fraction. Infinities of opposite sign give +infinity (0x7F800000). No output has exponent 255 with a non-zero fraction.
- R5: If the result exponent reaches 255, nearest mode returns a signed infinity. Truncation mode instead returns the largest finite magnitude, 0x7F7FFFFF with the result sign.
- R6: An operand with exponent field 0 is a zero of its own sign. A result below the smallest normal magnitude becomes a zero carrying the sign of the larger operand. No output has exponent 0 with a non-zero fraction.
- R7: An exactly zero sum of operands of opposite sign is +0 in both modes. Two zeros of the same sign keep that sign.
- R8: A rounding increment that carries out of the fraction renormalizes and raises the exponent: 0x3F7FFFFF + 0x33000000 gives 0x3F800000 in nearest mode and 0x3F7FFFFF in truncation.
- R9: Every result equals the exactly rounded sum under the selected mode, for any normal operands. This includes alignment across large exponent gaps and cancellation in subtraction. Accumulating 0x413B3333 repeatedly gives different totals in the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| rnd_near | input | 1 | Rounding select: 1 nearest-even, 0 truncation |
| out_valid | output | 1 | Result present this cycle |
| sum | output | 32 | Binary32 sum |

## Verification
A wrong alignment shift or a lost sticky bit shows at the ports only as a last-place error. It appears two cycles after the operands, and only for pairs whose exponent gap pushes set bits past the round position. The stimulus therefore spans small and large gaps in both modes. A rounding or tie decision that goes the wrong way flips the fraction's lowest bit. In a long accumulation of 11.7 that error compounds, so one bad decision is visible at every later output. A pipeline register that is enabled wrongly shows up as a missing or extra strobe, or as one pair's result appearing in a neighbour's slot during back-to-back issue.

// File: rtl/sp_fadd_pkg.sv
package sp_fadd_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int FRAC_W  = MAN_W + 1;
  localparam int GRS_W   = 3;
  localparam int ALN_W   = FRAC_W + GRS_W;
  localparam int SUM_W   = ALN_W + 1;
  localparam int CNT_W   = $clog2(ALN_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SUM_W-1:0]  mag;
    logic              special;
    logic [WORD_W-1:0] spec_val;
    logic              near;
  } stage1_t;
endpackage

// File: rtl/sp_fadd_align.sv
module sp_fadd_align
  import sp_fadd_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              near,
  output stage1_t           s1
);
  logic              sa, sb, inf_a, inf_b, swap, eff_sub;
  logic [EXP_W-1:0]  ea, eb, e_big, e_sml, diff, sh;
  logic [FRAC_W-1:0] fa, fb, f_big, f_sml;
  logic [ALN_W-1:0]  ext, shifted, lost, aligned, big_ext;
  logic              s_big;
  logic [SUM_W-1:0]  mag;

  always_comb begin
    sa    = op_a[WORD_W-1];
    sb    = op_b[WORD_W-1];
    ea    = op_a[WORD_W-2:MAN_W];
    eb    = op_b[WORD_W-2:MAN_W];
    inf_a = &ea;
    inf_b = &eb;
    // exponent field 0 flushes the operand to a signed zero
    fa    = (ea == '0) ? '0 : {1'b1, op_a[MAN_W-1:0]};
    fb    = (eb == '0) ? '0 : {1'b1, op_b[MAN_W-1:0]};
    swap  = {eb, fb} > {ea, fa};
    s_big = swap ? sb : sa;
    e_big = swap ? eb : ea;
    f_big = swap ? fb : fa;
    e_sml = swap ? ea : eb;
    f_sml = swap ? fa : fb;
    diff  = e_big - e_sml;
    sh    = (diff > EXP_W'(ALN_W)) ? EXP_W'(ALN_W) : diff;
    ext     = {f_sml, {GRS_W{1'b0}}};
    shifted = ext >> sh;
    lost    = ext & ~({ALN_W{1'b1}} << sh);
    aligned = shifted | {{(ALN_W-1){1'b0}}, |lost};
    big_ext = {f_big, {GRS_W{1'b0}}};
    eff_sub = sa ^ sb;
    mag     = eff_sub ? ({1'b0, big_ext} - {1'b0, aligned})
                      : ({1'b0, big_ext} + {1'b0, aligned});

    s1.exp     = e_big;
    s1.mag     = mag;
    s1.near    = near;
    s1.sign    = (eff_sub && mag == '0) ? 1'b0 : s_big;
    s1.special = inf_a | inf_b;
    if (inf_a && inf_b && eff_sub)
      s1.spec_val = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (inf_a)
      s1.spec_val = {sa, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else
      s1.spec_val = {sb, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  end
endmodule

// File: rtl/sp_fadd_round.sv
module sp_fadd_round
  import sp_fadd_pkg::*;
(
  input  stage1_t           r,
  output logic [WORD_W-1:0] y
);
  localparam int EW = EXP_W + 2;

  function automatic logic [CNT_W-1:0] lead_zeros(logic [ALN_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = CNT_W'(ALN_W);
    for (int i = 0; i < ALN_W; i++)
      if (v[i]) n = CNT_W'(ALN_W - 1 - i);
    return n;
  endfunction

  logic [CNT_W-1:0]  lz;
  logic [ALN_W-1:0]  norm;
  logic signed [EW-1:0] e_norm, e_fin;
  logic [FRAC_W-1:0] keep;
  logic [FRAC_W:0]   rnd;
  logic              inc;
  logic [MAN_W-1:0]  man_out;

  always_comb begin
    lz = lead_zeros(r.mag[ALN_W-1:0]);
    if (r.mag[SUM_W-1]) begin
      norm   = r.mag[SUM_W-1:1] | {{(ALN_W-1){1'b0}}, r.mag[0]};
      e_norm = signed'(EW'(r.exp)) + signed'(EW'(1));
    end else begin
      norm   = r.mag[ALN_W-1:0] << lz;
      e_norm = signed'(EW'(r.exp)) - signed'(EW'(lz));
    end
    keep = norm[ALN_W-1:GRS_W];
    inc  = r.near & norm[GRS_W-1] & ((|norm[GRS_W-2:0]) | keep[0]);
    rnd  = {1'b0, keep} + {{FRAC_W{1'b0}}, inc};
    if (rnd[FRAC_W]) begin
      man_out = '0;
      e_fin   = e_norm + signed'(EW'(1));
    end else begin
      man_out = rnd[MAN_W-1:0];
      e_fin   = e_norm;
    end

    if (r.special)
      y = r.spec_val;
    else if (r.mag == '0)
      y = {r.sign, {(WORD_W-1){1'b0}}};
    else if (e_fin >= signed'(EW'(EXP_MAX)))
      y = r.near ? {r.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                 : {r.sign, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
    else if (e_fin <= signed'(EW'(0)))
      y = {r.sign, {(WORD_W-1){1'b0}}};
    else
      y = {r.sign, e_fin[EXP_W-1:0], man_out};
  end
endmodule

// File: rtl/sp_fadd.sv
module sp_fadd
  import sp_fadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              rnd_near,
  output logic              out_valid,
  output logic [WORD_W-1:0] sum
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  stage1_t           s1_d, s1_q;
  logic              v1_q;
  logic [WORD_W-1:0] y_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sp_fadd_align u_align (.op_a(op_a), .op_b(op_b), .near(rnd_near), .s1(s1_d));
  sp_fadd_round u_round (.r(s1_q), .y(y_d));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      v1_q      <= 1'b0;
      s1_q      <= '0;
      out_valid <= 1'b0;
      sum       <= '0;
    end else begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
      if (in_valid) s1_q <= s1_d;
      if (v1_q)     sum  <= y_d;
    end
  end
endmodule

// File: rtl/sp_fadd_chk.sv
module sp_fadd_chk
  import sp_fadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              rnd_near,
  input logic              out_valid,
  input logic [WORD_W-1:0] sum
);
  logic [WORD_W-1:0] a_q1, a_q2, b_q1, b_q2;
  logic              m_q1, m_q2;
  logic              a_inf, b_inf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q1 <= '0; a_q2 <= '0; b_q1 <= '0; b_q2 <= '0;
      m_q1 <= 1'b0; m_q2 <= 1'b0;
    end else begin
      a_q1 <= op_a; a_q2 <= a_q1;
      b_q1 <= op_b; b_q2 <= b_q1;
      m_q1 <= rnd_near; m_q2 <= m_q1;
    end
  end

  assign a_inf = &a_q2[WORD_W-2:MAN_W];
  assign b_inf = &b_q2[WORD_W-2:MAN_W];

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_no_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((&sum[WORD_W-2:MAN_W]) && (|sum[MAN_W-1:0])));
  assert_inf_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (a_inf || b_inf)) |-> (sum[WORD_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));
  assert_opp_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && a_inf && b_inf && (a_q2[WORD_W-1] != b_q2[WORD_W-1]))
      |-> !sum[WORD_W-1]);
  assert_trunc_finite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !m_q2 && !a_inf && !b_inf) |-> (sum[WORD_W-2:MAN_W] != {EXP_W{1'b1}}));
  assert_no_denorm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((sum[WORD_W-2:MAN_W] == '0) && (|sum[MAN_W-1:0])));
endmodule

bind sp_fadd sp_fadd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .rnd_near(rnd_near), .out_valid(out_valid), .sum(sum)
);

// File: tb/sim_sp_fadd.sv
module sim_sp_fadd;
  logic        clk, rst_n, in_valid, rnd_near, out_valid;
  logic [31:0] op_a, op_b, sum;
  int          n_chk, n_fail;
  logic        done;

  sp_fadd u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
              .op_b(op_b), .rnd_near(rnd_near), .out_valid(out_valid), .sum(sum));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b, logic near);
    logic sa, sb, s1, s2;
    int ea, eb, e1, e2, d, p, sh, e;
    logic [22:0] f1, f2;
    logic [65:0] A, B, R, mant, rem, half;
    logic up;
    sa = a[31]; sb = b[31];
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    if (ea == 255 || eb == 255) begin
      if (ea == 255 && eb == 255 && sa != sb) return 32'h7F800000;
      if (ea == 255) return {sa, 8'hFF, 23'h0};
      return {sb, 8'hFF, 23'h0};
    end
    if (ea == 0 && eb == 0) return {sa & sb, 31'h0};
    if (ea == 0) return b;
    if (eb == 0) return a;
    if ({b[30:23], b[22:0]} > {a[30:23], a[22:0]}) begin
      s1 = sb; e1 = eb; f1 = b[22:0]; s2 = sa; e2 = ea; f2 = a[22:0];
    end else begin
      s1 = sa; e1 = ea; f1 = a[22:0]; s2 = sb; e2 = eb; f2 = b[22:0];
    end
    d = e1 - e2;
    A = {42'h0, 1'b1, f1} << 39;
    B = (d <= 39) ? ({42'h0, 1'b1, f2} << (39 - d)) : 66'd1;
    R = (s1 == s2) ? A + B : A - B;
    if (R == 66'd0) return 32'h0;
    p = 0;
    for (int i = 0; i < 66; i++) if (R[i]) p = i;
    e = e1 + p - 62;
    up = 1'b0;
    if (p > 23) begin
      sh   = p - 23;
      mant = R >> sh;
      rem  = R & ((66'd1 << sh) - 66'd1);
      half = 66'd1 << (sh - 1);
      up   = near && (rem > half || (rem == half && mant[0]));
    end else begin
      mant = R << (23 - p);
    end
    if (up) mant = mant + 66'd1;
    if (mant == (66'd1 << 24)) begin mant = mant >> 1; e = e + 1; end
    if (e >= 255) return near ? {s1, 8'hFF, 23'h0} : {s1, 8'hFE, 23'h7FFFFF};
    if (e <= 0) return {s1, 31'h0};
    return {s1, e[7:0], mant[22:0]};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] a, logic [31:0] b, logic near,
                     output logic [31:0] res);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; rnd_near = near;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 strobe early", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check("R1 strobe", {31'h0, out_valid}, 32'h1);
    check(tag, sum, ref_add(a, b, near));
    res = sum;
  endtask

  task automatic dir(string tag, logic [31:0] a, logic [31:0] b, logic near,
                     logic [31:0] exp);
    logic [31:0] r;
    run(tag, a, b, near, r);
    check({tag, " directed"}, r, exp);
  endtask

  function automatic logic [31:0] rnd_op(int base);
    int e;
    case ($urandom % 16)
      0: e = 0;
      1: e = 255;
      2: e = 254 - int'($urandom % 3);
      3: e = 1 + int'($urandom % 3);
      default: e = base + int'($urandom % 9) - 4;
    endcase
    if (e < 0) e = 0;
    if (e > 255) e = 255;
    return {1'($urandom), e[7:0], 23'($urandom)};
  endfunction

  logic [31:0] qa [32];
  logic [31:0] qb [32];
  logic        qm [32];

  initial begin
    logic [31:0] r, acc_n, acc_t;
    n_chk = 0; n_fail = 0; done = 1'b0;
    in_valid = 1'b0; op_a = '0; op_b = '0; rnd_near = 1'b1;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("reset out_valid", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {31'h0, out_valid}, 32'h0);

    dir("R2 trunc drop", 32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800000);
    dir("R3 above half", 32'h3F800000, 32'h33C00000, 1'b1, 32'h3F800001);
    dir("R3 tie even down", 32'h3F800000, 32'h33800000, 1'b1, 32'h3F800000);
    dir("R3 tie odd up", 32'h3F800001, 32'h33800000, 1'b1, 32'h3F800002);
    dir("R8 carry near", 32'h3F7FFFFF, 32'h33000000, 1'b1, 32'h3F800000);
    dir("R8 carry trunc", 32'h3F7FFFFF, 32'h33000000, 1'b0, 32'h3F7FFFFF);
    dir("R5 ovf near", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b1, 32'h7F800000);
    dir("R5 ovf trunc", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F7FFFFF);
    dir("R5 ovf trunc neg", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF7FFFFF);
    dir("R4 nan pos", 32'h7FC00000, 32'h3F800000, 1'b1, 32'h7F800000);
    dir("R4 nan neg", 32'hFFC00001, 32'h3F800000, 1'b0, 32'hFF800000);
    dir("R4 opp inf", 32'h7F800000, 32'hFF800000, 1'b1, 32'h7F800000);
    dir("R6 denorm pair", 32'h00000001, 32'h00000001, 1'b1, 32'h00000000);
    dir("R6 denorm operand", 32'h00400000, 32'h3F800000, 1'b1, 32'h3F800000);
    dir("R6 underflow sign", 32'h80800001, 32'h00800000, 1'b1, 32'h80000000);
    dir("R7 cancel near", 32'h3F800000, 32'hBF800000, 1'b1, 32'h00000000);
    dir("R7 cancel trunc", 32'hC1200000, 32'h41200000, 1'b0, 32'h00000000);
    dir("R7 neg zeros", 32'h80000000, 32'h80000000, 1'b1, 32'h80000000);

    for (int i = 0; i < 2500; i++) begin
      int base;
      base = 60 + int'($urandom % 130);
      run("R9 random", rnd_op(base), rnd_op(base), 1'($urandom), r);
    end

    // back-to-back issue
    for (int i = 0; i < 32; i++) begin
      qa[i] = rnd_op(127); qb[i] = rnd_op(127); qm[i] = 1'($urandom);
    end
    for (int i = 0; i < 34; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R1 burst strobe", {31'h0, out_valid}, 32'h1);
        check("R1 burst data", sum, ref_add(qa[i-2], qb[i-2], qm[i-2]));
      end
      if (i < 32) begin
        in_valid = 1'b1; op_a = qa[i]; op_b = qb[i]; rnd_near = qm[i];
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R1 burst end", {31'h0, out_valid}, 32'h0);

    acc_n = 32'h0; acc_t = 32'h0;
    for (int i = 0; i < 400; i++) begin
      run("R9 accumulate near", acc_n, 32'h413B3333, 1'b1, r); acc_n = r;
      run("R9 accumulate trunc", acc_t, 32'h413B3333, 1'b0, r); acc_t = r;
    end
    n_chk++;
    if (acc_n == acc_t || acc_t > acc_n) begin
      n_fail++;
      $display("FAIL R9 modes: trunc %h near %h, expected trunc below near", acc_t, acc_n);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule